// File: doc/BRIEF.md
# Shader Temporary Register Allocator

This block shares one physical temporary register file among all threads of a shader unit. When a shader program is bound, the block receives the number of live temporaries that program uses. It rounds that count up to the allocation unit of two registers per thread. From the result it works out how many threads fit in the file, and so how many four-thread groups may be resident at once.

Thread groups are launched with a request and retired by slot index. On each launch the block grants the lowest-numbered free group slot inside the current limit, together with the base address of that group's region in the file. The four threads of a group share one program counter, and each thread owns a contiguous block of `per_thread` registers starting at that base.

A new program configuration is applied only when no group is resident. While a configure request is pending, no new groups are launched, so the unit drains. Storage of the register file, its read ports and instruction decode sit outside this block.

Top module: `treg_alloc`

## Requirements
- R1: After reset the allocation is 4 registers per thread, the thread limit is 128 and every group slot is free, so the first grant is slot 0 with base 0.
- R2: On an accepted configure, the per-thread allocation becomes the requested count rounded up to an even number, and a request of 0 gives 2. The new value is visible from the cycle after acceptance.
- R3: The thread limit is the lesser of MAX_THREADS and FILE_REGS divided by the per-thread allocation, rounded down to a multiple of 4. The group limit is the thread limit divided by 4.
- R4: With alloc_req high, cfg_req low and at least one free slot below the group limit, alloc_grant is high in the same cycle and alloc_slot is the lowest such free slot.
- R5: A granted group's alloc_base equals alloc_slot × 4 × per_thread.
- R6: When every slot below the group limit is busy, alloc_req is not granted.
- R7: A slot is busy from the clock edge after its grant. free_req with free_slot releases that slot at the next edge. Releasing a slot that is already free has no effect.
- R8: cfg_ack is high in the same cycle as cfg_req only when no slot is busy. While cfg_req is high, no grant is given.
- R9: A grant and a release of a different slot in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_req | input | 1 | Request to bind a new program's temporary count |
| cfg_temps | input | TEMP_W | Live temporaries used by the new program |
| cfg_ack | output | 1 | Configuration accepted this cycle |
| alloc_req | input | 1 | Launch request for one thread group |
| alloc_grant | output | 1 | Launch granted this cycle |
| alloc_slot | output | SLOT_W | Granted group slot |
| alloc_base | output | ADDR_W | First register of the granted group |
| free_req | input | 1 | Retire a group |
| free_slot | input | SLOT_W | Slot being retired |
| per_thread | output | TEMP_W+1 | Registers allocated per thread |
| thread_limit | output | TL_W | Threads that may be resident |

## Verification
The hardest state to reach is a configure request that is held off and then accepted. It needs groups to be resident, the request held across several cycles while launches are refused, and then every group retired before acceptance. The bench builds that state by launching groups and raising cfg_req with alloc_req still asserted. It then retires the slots one at a time and expects cfg_ack only on the cycle after the last release. A second hard case is filling every slot under a small, non-power-of-two group limit (21 groups at 6 registers per thread). The bench reaches it by configuring 5 temporaries and launching until a refusal appears.

// File: rtl/treg_alloc.sv
module treg_alloc #(
  parameter int FILE_REGS   = 512,
  parameter int MAX_THREADS = 128,
  parameter int GROUP_SIZE  = 4,
  parameter int TEMP_W      = 6,
  parameter int RESET_TEMPS = 4,
  localparam int MAX_GROUPS = MAX_THREADS / GROUP_SIZE,
  localparam int SLOT_W     = $clog2(MAX_GROUPS),
  localparam int GL_W       = $clog2(MAX_GROUPS + 1),
  localparam int ADDR_W     = $clog2(FILE_REGS),
  localparam int TL_W       = $clog2(MAX_THREADS + 1),
  localparam int PT_W       = TEMP_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_req,
  input  logic [TEMP_W-1:0] cfg_temps,
  output logic              cfg_ack,
  input  logic              alloc_req,
  output logic              alloc_grant,
  output logic [SLOT_W-1:0] alloc_slot,
  output logic [ADDR_W-1:0] alloc_base,
  input  logic              free_req,
  input  logic [SLOT_W-1:0] free_slot,
  output logic [PT_W-1:0]   per_thread,
  output logic [TL_W-1:0]   thread_limit
);

  function automatic logic [PT_W-1:0] round_per(input logic [TEMP_W-1:0] t);
    logic [PT_W-1:0] te;
    te = {1'b0, t};
    if (t == '0) return PT_W'(2);
    return (te + PT_W'(1)) & ~PT_W'(1);
  endfunction

  function automatic logic [TL_W-1:0] fit_threads(input logic [PT_W-1:0] p);
    logic [31:0] n;
    n = 32'(FILE_REGS) / 32'(p);
    if (n > 32'(MAX_THREADS)) n = 32'(MAX_THREADS);
    n = (n / 32'(GROUP_SIZE)) * 32'(GROUP_SIZE);
    return TL_W'(n);
  endfunction

  localparam logic [PT_W-1:0] RST_PER = round_per(TEMP_W'(RESET_TEMPS));
  localparam logic [TL_W-1:0] RST_LIM = fit_threads(RST_PER);

  logic [MAX_GROUPS-1:0] slot_map;
  logic [PT_W-1:0]       per_q;
  logic [TL_W-1:0]       lim_q;
  logic [GL_W-1:0]       glim_q;
  logic [PT_W-1:0]       new_per;
  logic [TL_W-1:0]       new_lim;
  logic                  found;
  logic [SLOT_W-1:0]     pick;
  logic [MAX_GROUPS-1:0] set_mask, clr_mask;

  assign new_per = round_per(cfg_temps);
  assign new_lim = fit_threads(new_per);

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = MAX_GROUPS - 1; i >= 0; i--) begin
      if (!slot_map[i] && (GL_W'(i) < glim_q)) begin
        found = 1'b1;
        pick  = SLOT_W'(i);
      end
    end
  end

  assign cfg_ack     = cfg_req && (slot_map == '0);
  assign alloc_grant = alloc_req && !cfg_req && found;
  assign alloc_slot  = pick;
  assign alloc_base  = ADDR_W'(32'(pick) * 32'(GROUP_SIZE) * 32'(per_q));
  assign per_thread  = per_q;
  assign thread_limit = lim_q;

  assign set_mask = alloc_grant ? (MAX_GROUPS'(1) << pick) : '0;
  assign clr_mask = free_req ? (MAX_GROUPS'(1) << free_slot) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_map <= '0;
      per_q    <= RST_PER;
      lim_q    <= RST_LIM;
      glim_q   <= GL_W'(RST_LIM / TL_W'(GROUP_SIZE));
    end else begin
      slot_map <= (slot_map & ~clr_mask) | set_mask;
      if (cfg_ack) begin
        per_q  <= new_per;
        lim_q  <= new_lim;
        glim_q <= GL_W'(new_lim / TL_W'(GROUP_SIZE));
      end
    end
  end

endmodule

// File: rtl/treg_alloc_chk.sv
module treg_alloc_chk #(
  parameter int FILE_REGS   = 512,
  parameter int MAX_THREADS = 128,
  parameter int GROUP_SIZE  = 4,
  parameter int MAX_GROUPS  = 32,
  parameter int SLOT_W      = 5,
  parameter int ADDR_W      = 9,
  parameter int TL_W        = 8,
  parameter int PT_W        = 7
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cfg_req,
  input logic                  cfg_ack,
  input logic                  alloc_grant,
  input logic [SLOT_W-1:0]     alloc_slot,
  input logic [ADDR_W-1:0]     alloc_base,
  input logic [PT_W-1:0]       per_thread,
  input logic [TL_W-1:0]       thread_limit,
  input logic [MAX_GROUPS-1:0] slot_map
);

  p_per_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (per_thread[0] == 1'b0) && (per_thread != '0));

  p_limit_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(thread_limit) <= 32'(MAX_THREADS)) && ((32'(thread_limit) % 32'(GROUP_SIZE)) == 0));

  p_grant_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_grant |-> !slot_map[alloc_slot]);

  p_base_fits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_grant |-> (32'(alloc_base) + 32'(GROUP_SIZE) * 32'(per_thread) <= 32'(FILE_REGS)));

  p_slot_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_grant |-> (32'(alloc_slot) < 32'(thread_limit) / 32'(GROUP_SIZE)));

  p_mark_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_grant |=> slot_map[$past(alloc_slot)]);

  p_cfg_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> !alloc_grant);

  p_ack_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ack |=> (slot_map == '0));

endmodule

bind treg_alloc treg_alloc_chk #(
  .FILE_REGS(FILE_REGS), .MAX_THREADS(MAX_THREADS), .GROUP_SIZE(GROUP_SIZE),
  .MAX_GROUPS(MAX_GROUPS), .SLOT_W(SLOT_W), .ADDR_W(ADDR_W), .TL_W(TL_W), .PT_W(PT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_ack(cfg_ack),
  .alloc_grant(alloc_grant), .alloc_slot(alloc_slot), .alloc_base(alloc_base),
  .per_thread(per_thread), .thread_limit(thread_limit), .slot_map(slot_map)
);

// File: tb/sim_treg_alloc.sv
module sim_treg_alloc;
  localparam int PERIOD = 10;
  localparam int NG = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_req = 1'b0;
  logic [5:0] cfg_temps = '0;
  logic       cfg_ack;
  logic       alloc_req = 1'b0;
  logic       alloc_grant;
  logic [4:0] alloc_slot;
  logic [8:0] alloc_base;
  logic       free_req = 1'b0;
  logic [4:0] free_slot = '0;
  logic [6:0] per_thread;
  logic [7:0] thread_limit;

  int checks = 0;
  int errors = 0;
  int m_per = 4;
  int m_lim = 128;
  bit m_busy[NG];

  always #(PERIOD/2) clk = ~clk;

  treg_alloc u0 (
    .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_temps(cfg_temps), .cfg_ack(cfg_ack),
    .alloc_req(alloc_req), .alloc_grant(alloc_grant), .alloc_slot(alloc_slot),
    .alloc_base(alloc_base), .free_req(free_req), .free_slot(free_slot),
    .per_thread(per_thread), .thread_limit(thread_limit)
  );

  task automatic chk(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0d exp %0d", tag, what, got, exp);
    end
  endtask

  function automatic int m_round(input int t);
    if (t == 0) return 2;
    return ((t + 1) / 2) * 2;
  endfunction

  function automatic int m_fit(input int p);
    int n;
    n = 512 / p;
    if (n > 128) n = 128;
    return (n / 4) * 4;
  endfunction

  // one clock: drive at negedge, compare, advance model at posedge
  task automatic cyc(input bit cr, input int ct, input bit ar, input bit fr, input int fs,
                     input string tag);
    int  used, eslot;
    bit  eack, egrant;
    cfg_req = cr; cfg_temps = 6'(ct); alloc_req = ar; free_req = fr; free_slot = 5'(fs);
    #1;
    used = 0;
    foreach (m_busy[i]) used += m_busy[i];
    eack = cr && (used == 0);
    eslot = -1;
    for (int i = NG - 1; i >= 0; i--)
      if (!m_busy[i] && i < m_lim / 4) eslot = i;
    egrant = ar && !cr && (eslot >= 0);
    chk(tag, "cfg_ack", int'(cfg_ack), int'(eack));
    chk(tag, "alloc_grant", int'(alloc_grant), int'(egrant));
    chk(tag, "per_thread", int'(per_thread), m_per);
    chk(tag, "thread_limit", int'(thread_limit), m_lim);
    if (egrant) begin
      chk(tag, "alloc_slot", int'(alloc_slot), eslot);
      chk(tag, "alloc_base", int'(alloc_base), eslot * 4 * m_per);
    end
    @(posedge clk);
    if (fr) m_busy[fs] = 1'b0;
    if (egrant) m_busy[eslot] = 1'b1;
    if (eack) begin
      m_per = m_round(ct);
      m_lim = m_fit(m_per);
    end
    @(negedge clk);
  endtask

  task automatic idle(input string tag);
    cyc(0, 0, 0, 0, 0, tag);
  endtask

  task automatic free_all(input string tag);
    for (int s = 0; s < NG; s++) cyc(0, 0, 0, 1, s, tag);
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, first grant slot 0 base 0
    idle("R1");
    cyc(0, 0, 1, 0, 0, "R1");
    // R4 R5: successive grants take the lowest slots
    cyc(0, 0, 1, 0, 0, "R4");
    cyc(0, 0, 1, 0, 0, "R5");
    // R7: release slot 1, it is given out again
    cyc(0, 0, 0, 1, 1, "R7");
    cyc(0, 0, 1, 0, 0, "R7");
    // R7: releasing a free slot (5) changes nothing, next grant is slot 3
    cyc(0, 0, 0, 1, 5, "R7");
    cyc(0, 0, 1, 0, 0, "R7");
    // R9: grant slot 4 while releasing slot 0, then slot 0 is granted
    cyc(0, 0, 1, 1, 0, "R9");
    cyc(0, 0, 1, 0, 0, "R9");
    // R8: configure held off while groups are resident, launches refused
    for (int k = 0; k < 3; k++) cyc(1, 5, 1, 0, 0, "R8");
    for (int s = 0; s < 5; s++) cyc(1, 5, 1, 1, s, "R8");
    // R8 R2 R3: now idle, accepted; 5 temps -> 6 per thread, 84 threads
    cyc(1, 5, 0, 0, 0, "R8");
    idle("R2");
    // R6: fill all 21 groups, further requests refused
    for (int k = 0; k < 23; k++) cyc(0, 0, 1, 0, 0, "R6");
    free_all("R7");
    // R2: zero temporaries -> 2 per thread, capped at 128 threads (R3)
    cyc(1, 0, 0, 0, 0, "R2");
    idle("R3");
    cyc(0, 0, 1, 0, 0, "R5");
    free_all("R7");
    // R3: 63 temps -> 64 per thread -> 8 threads, 2 groups
    cyc(1, 63, 0, 0, 0, "R3");
    for (int k = 0; k < 4; k++) cyc(0, 0, 1, 0, 0, "R6");
    free_all("R7");
    // R2: odd request 7 -> 8
    cyc(1, 7, 0, 0, 0, "R2");
    idle("R2");
    // mixed traffic against the model
    for (int k = 0; k < 400; k++) begin
      bit cr, ar, fr;
      cr = ($urandom % 16) == 0;
      ar = ($urandom % 3) != 0;
      fr = ($urandom % 2) == 0;
      cyc(cr, int'($urandom % 64), ar, fr, int'($urandom % NG), "R4");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule